// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers interrupt causes from a bank of DMA channels and routes them to four independent interrupt destinations. Every channel raises two kinds of cause, a descriptor-completed pulse and an error pulse. Each cause is latched into a per-channel status word, and that word exists once for each destination. A per-channel, per-destination mask word decides which latched causes reach that destination.

Channels come in pairs. Even channels move data from memory to a device (transmit) and odd channels move data from a device to memory (receive). For each destination the block keeps two summary vectors, one per direction, where bit `ch/2` shows that the channel has an unmasked pending cause. A destination's interrupt line is high while either of its summaries is nonzero. Software reads the summaries to find the channels that need service. It then clears their status bits by writing ones to them.

Top module: `dmairq_top`

## Requirements
- R1: After reset all status and mask bits are 0, every summary reads 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: A done pulse on a channel sets status bit 0, and an error pulse sets status bit 6, in all four destination copies of that channel's status, whatever the mask holds. The bit is readable on the cycle after the pulse.
- R3: A write to a status word clears each bit written as 1 and leaves bits written as 0 unchanged. It acts on that one channel and destination only.
- R4: A cause pulse in the same cycle as a write-1-clear of the same status bit leaves the bit set.
- R5: A mask word holds bit 0 (done enable) and bit 6 (error enable). A write replaces both. All other bits read as 0. Masks change only on a write.
- R6: The transmit summary of destination `d` has bit `k` set exactly when channel `2k` has a status bit set whose mask bit for `d` is also set.
- R7: The receive summary of destination `d` has bit `k` set exactly when channel `2k+1` has an unmasked pending cause for `d`.
- R8: `irq_out[d]` is high exactly while the transmit or receive summary of `d` is nonzero. It follows a status or mask change in the same cycle the register changes. Destinations do not affect one another.
- R9: With the error enable cleared and the done enable set, an error cause does not raise the interrupt, while a done cause does.
- R10: Byte address map. Transmit summary of `d` is at `0x000 + 4d` and receive summary at `0x010 + 4d`. Channel `c` status for `d` is at `0x100 + 32c + 4d` and its mask at `0x110 + 32c + 4d`. Reads return data on the cycle after `bus_rd`. Unmapped addresses, including channels at or above `NUM_CH`, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_pulse | input | NUM_CH | Per-channel descriptor-completed cause pulse |
| err_pulse | input | NUM_CH | Per-channel error cause pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 4 | One interrupt line per destination |

## Verification
The bench targets the race between a cause pulse and a write-1-clear of the same bit. A design that lets the clear win would lose a completion. It checks that a masked error still latches in status while the line stays low. A design that gates the latch with the mask would hide causes from later polling. It places transmit and receive channels on the same destination and clears them one at a time: a design that ORs the wrong summary or folds channel numbers incorrectly drops the line early or sets the wrong summary bit. It also writes to a channel number just beyond the last one. A decoder without that bound would alias onto a real channel.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NUM_DEST = 4;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 6;

  typedef enum logic [2:0] {
    RK_NONE, RK_TXSUM, RK_RXSUM, RK_STAT, RK_MASK
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [6:0] ch;
    logic [1:0] idx;
  } reg_sel_t;

  // Map a byte address onto a register class, channel and destination.
  function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int unsigned nch);
    reg_sel_t   s;
    logic [6:0] c;
    s.kind = RK_NONE;
    s.ch   = '0;
    s.idx  = a[3:2];
    c      = a[11:5] - 7'd8;
    if (a[1:0] == 2'b00) begin
      if (a[11:8] == 4'h0) begin
        if (a[7:4] == 4'h0)      s.kind = RK_TXSUM;
        else if (a[7:4] == 4'h1) s.kind = RK_RXSUM;
      end else if (32'(c) < nch) begin
        s.ch   = c;
        s.kind = a[4] ? RK_MASK : RK_STAT;
      end
    end
    return s;
  endfunction

  // Place the two cause bits at their word positions.
  function automatic logic [DATA_W-1:0] cause_word(logic done_b, logic err_b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DONE_BIT] = done_b;
    w[ERR_BIT]  = err_b;
    return w;
  endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              wdata_done,
  input  logic                              wdata_err,
  output reg_sel_t                          sel,
  output logic [NUM_CH-1:0][NUM_DEST-1:0]   clr_done,
  output logic [NUM_CH-1:0][NUM_DEST-1:0]   clr_err,
  output logic [NUM_CH-1:0][NUM_DEST-1:0]   mask_we
);
  assign sel = decode_addr(bus_addr, NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dst
      logic hit;
      assign hit = bus_wr && (sel.ch == 7'(c)) && (sel.idx == 2'(d));
      assign clr_done[c][d] = hit && (sel.kind == RK_STAT) && wdata_done;
      assign clr_err[c][d]  = hit && (sel.kind == RK_STAT) && wdata_err;
      assign mask_we[c][d]  = hit && (sel.kind == RK_MASK);
    end
  end
endmodule

// File: rtl/irq_cause_cell.sv
module irq_cause_cell
  import dmairq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_i,
  input  logic                err_i,
  input  logic [NUM_DEST-1:0] clr_done,
  input  logic [NUM_DEST-1:0] clr_err,
  input  logic [NUM_DEST-1:0] mask_we,
  input  logic                mask_done_in,
  input  logic                mask_err_in,
  output logic [NUM_DEST-1:0] st_done,
  output logic [NUM_DEST-1:0] st_err,
  output logic [NUM_DEST-1:0] mk_done,
  output logic [NUM_DEST-1:0] mk_err,
  output logic [NUM_DEST-1:0] pend
);
  // A new cause outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_done <= '0;
      st_err  <= '0;
    end else begin
      st_done <= (st_done & ~clr_done) | {NUM_DEST{done_i}};
      st_err  <= (st_err  & ~clr_err)  | {NUM_DEST{err_i}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk_done <= '0;
      mk_err  <= '0;
    end else begin
      for (int d = 0; d < NUM_DEST; d++) begin
        if (mask_we[d]) begin
          mk_done[d] <= mask_done_in;
          mk_err[d]  <= mask_err_in;
        end
      end
    end
  end

  assign pend = (st_done & mk_done) | (st_err & mk_err);
endmodule

// File: rtl/irq_route.sv
module irq_route
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int HALF = NUM_CH / 2
) (
  input  logic [NUM_CH-1:0][NUM_DEST-1:0] pend,
  output logic [NUM_DEST-1:0][HALF-1:0]   tx_sum,
  output logic [NUM_DEST-1:0][HALF-1:0]   rx_sum,
  output logic [NUM_DEST-1:0]             irq
);
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dst
    for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign tx_sum[d][k] = pend[2*k][d];
      assign rx_sum[d][k] = pend[2*k+1][d];
    end
    assign irq[d] = (|tx_sum[d]) | (|rx_sum[d]);
  end
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     done_pulse,
  input  logic [NUM_CH-1:0]     err_pulse,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_DEST-1:0]   irq_out
);
  localparam int HALF = NUM_CH / 2;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_sel_t                         sel;
  logic [NUM_CH-1:0][NUM_DEST-1:0]  clr_done_w, clr_err_w, mask_we_w;
  logic [NUM_CH-1:0][NUM_DEST-1:0]  st_done_w, st_err_w, mk_done_w, mk_err_w, pend_w;
  logic [NUM_DEST-1:0][HALF-1:0]    tx_sum, rx_sum;
  logic [CH_W-1:0]                  rd_ch;
  logic                             unused_bits;

  assign unused_bits = ^{bus_wdata, sel.ch};
  assign rd_ch       = sel.ch[CH_W-1:0];

  irq_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_done (bus_wdata[DONE_BIT]),
    .wdata_err  (bus_wdata[ERR_BIT]),
    .sel        (sel),
    .clr_done   (clr_done_w),
    .clr_err    (clr_err_w),
    .mask_we    (mask_we_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
    irq_cause_cell u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .done_i       (done_pulse[c]),
      .err_i        (err_pulse[c]),
      .clr_done     (clr_done_w[c]),
      .clr_err      (clr_err_w[c]),
      .mask_we      (mask_we_w[c]),
      .mask_done_in (bus_wdata[DONE_BIT]),
      .mask_err_in  (bus_wdata[ERR_BIT]),
      .st_done      (st_done_w[c]),
      .st_err       (st_err_w[c]),
      .mk_done      (mk_done_w[c]),
      .mk_err       (mk_err_w[c]),
      .pend         (pend_w[c])
    );
  end

  irq_route #(.NUM_CH(NUM_CH)) u_route (
    .pend   (pend_w),
    .tx_sum (tx_sum),
    .rx_sum (rx_sum),
    .irq    (irq_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (sel.kind)
        RK_TXSUM: bus_rdata <= DATA_W'(tx_sum[sel.idx]);
        RK_RXSUM: bus_rdata <= DATA_W'(rx_sum[sel.idx]);
        RK_STAT:  bus_rdata <= cause_word(st_done_w[rd_ch][sel.idx], st_err_w[rd_ch][sel.idx]);
        RK_MASK:  bus_rdata <= cause_word(mk_done_w[rd_ch][sel.idx], mk_err_w[rd_ch][sel.idx]);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmairq_checker.sv
module dmairq_checker
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_CH-1:0]                done_pulse,
  input logic [NUM_CH-1:0]                err_pulse,
  input logic                             bus_wr,
  input logic [NUM_DEST-1:0]              irq_out,
  input logic [NUM_CH-1:0][NUM_DEST-1:0]  st_done,
  input logic [NUM_CH-1:0][NUM_DEST-1:0]  st_err,
  input logic [NUM_CH-1:0][NUM_DEST-1:0]  mk_done,
  input logic [NUM_CH-1:0][NUM_DEST-1:0]  mk_err,
  input logic [NUM_CH-1:0][NUM_DEST-1:0]  clr_done,
  input logic [NUM_CH-1:0][NUM_DEST-1:0]  clr_err
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dst
      // R2 and R4: a pulse always leaves the bit set, even against a clear.
      a_r2_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse[c] |=> st_done[c][d]);
      a_r2_err_latch: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse[c] |=> st_err[c][d]);
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done[c][d] && !done_pulse[c]) |=> !st_done[c][d]);
      a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_err[c][d]) |-> $past(err_pulse[c]));
      a_r5_mask_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mk_done[c][d]) |-> $past(bus_wr));
    end
  end

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_irq
    a_r8_irq_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[d]) |-> $past((|done_pulse) || (|err_pulse) || bus_wr));
  end
endmodule

bind dmairq_top dmairq_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_pulse (done_pulse),
  .err_pulse  (err_pulse),
  .bus_wr     (bus_wr),
  .irq_out    (irq_out),
  .st_done    (st_done_w),
  .st_err     (st_err_w),
  .mk_done    (mk_done_w),
  .mk_err     (mk_err_w),
  .clr_done   (clr_done_w),
  .clr_err    (clr_err_w)
);

// File: tb/tb_dmairq_top.sv
module tb_dmairq_top;
  localparam int NCH = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  done_pulse = '0;
  logic [NCH-1:0]  err_pulse = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [3:0]      irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dmairq_top #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Address map (R10), written independently of the design.
  function automatic logic [11:0] a_stat(int ch, int d);
    return 12'(256 + ch * 32 + d * 4);
  endfunction
  function automatic logic [11:0] a_mask(int ch, int d);
    return 12'(256 + ch * 32 + 16 + d * 4);
  endfunction
  function automatic logic [11:0] a_tx(int d);
    return 12'(d * 4);
  endfunction
  function automatic logic [11:0] a_rx(int d);
    return 12'(16 + d * 4);
  endfunction
  function automatic logic [31:0] bits2word(logic [1:0] eb_db);
    return (eb_db[1] ? 32'h40 : 32'h0) | (eb_db[0] ? 32'h1 : 32'h0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic fire(int ch, logic [1:0] eb_db);
    @(negedge clk);
    done_pulse[ch] = eb_db[0];
    err_pulse[ch]  = eb_db[1];
    @(negedge clk);
    done_pulse = '0;
    err_pulse  = '0;
  endtask

  // Clear status at all destinations and the mask at one destination.
  task automatic scrub(int ch, int d);
    for (int i = 0; i < 4; i++) wr(a_stat(ch, i), 32'h41);
    wr(a_mask(ch, d), 32'h0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Vectors: channel, destination, mask {err,done}, cause {err,done}, expected irq.
  typedef struct packed {
    logic [6:0] ch;
    logic [1:0] d;
    logic [1:0] m;
    logic [1:0] c;
    logic [3:0] irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{ch: 7'd0,  d: 2'd0, m: 2'b01, c: 2'b01, irq: 4'b0001},
    '{ch: 7'd1,  d: 2'd2, m: 2'b11, c: 2'b10, irq: 4'b0100},
    '{ch: 7'd63, d: 2'd3, m: 2'b01, c: 2'b10, irq: 4'b0000},
    '{ch: 7'd62, d: 2'd1, m: 2'b10, c: 2'b01, irq: 4'b0000},
    '{ch: 7'd5,  d: 2'd1, m: 2'b11, c: 2'b11, irq: 4'b0010},
    '{ch: 7'd40, d: 2'd3, m: 2'b10, c: 2'b10, irq: 4'b1000},
    '{ch: 7'd7,  d: 2'd0, m: 2'b00, c: 2'b11, irq: 4'b0000},
    '{ch: 7'd20, d: 2'd2, m: 2'b01, c: 2'b11, irq: 4'b0100}
  };

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 irq", 32'(irq_out), 32'h0);
    rd(a_stat(3, 1), v);  check("R1 status", v, 32'h0);
    rd(a_mask(3, 1), v);  check("R1 mask", v, 32'h0);
    rd(a_tx(2), v);       check("R1 tx summary", v, 32'h0);
    rd(a_rx(0), v);       check("R1 rx summary", v, 32'h0);

    // Table walk: R2, R6, R7, R8, R9
    foreach (VECS[i]) begin
      int ch; int d; logic pend; logic [31:0] sum_exp;
      ch = int'(VECS[i].ch); d = int'(VECS[i].d);
      pend = |(VECS[i].m & VECS[i].c);
      sum_exp = pend ? (32'h1 << (ch / 2)) : 32'h0;
      wr(a_mask(ch, d), bits2word(VECS[i].m));
      fire(ch, VECS[i].c);
      check($sformatf("R8/R9 irq vec%0d", i), 32'(irq_out), 32'(VECS[i].irq));
      rd(a_stat(ch, (d + 1) % 4), v);
      check($sformatf("R2 status latch vec%0d", i), v, bits2word(VECS[i].c));
      rd(a_tx(d), v);
      check($sformatf("R6 tx summary vec%0d", i), v, (ch % 2 == 0) ? sum_exp : 32'h0);
      rd(a_rx(d), v);
      check($sformatf("R7 rx summary vec%0d", i), v, (ch % 2 == 1) ? sum_exp : 32'h0);
      scrub(ch, d);
      check($sformatf("R3 irq after clear vec%0d", i), 32'(irq_out), 32'h0);
    end

    // R3: partial clear and per-destination independence
    fire(4, 2'b11);
    wr(a_stat(4, 1), 32'h40);
    rd(a_stat(4, 1), v);  check("R3 clear err only", v, 32'h1);
    wr(a_stat(4, 1), 32'h1);
    rd(a_stat(4, 1), v);  check("R3 clear done", v, 32'h0);
    rd(a_stat(4, 2), v);  check("R3 other destination kept", v, 32'h41);
    scrub(4, 0);

    // R4: cause pulse in the same cycle as its clear
    fire(9, 2'b01);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a_stat(9, 0); bus_wdata = 32'h41; done_pulse[9] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; done_pulse = '0;
    rd(a_stat(9, 0), v);  check("R4 pulse beats clear", v, 32'h1);
    scrub(9, 0);

    // R5: mask holds only its two bits
    wr(a_mask(11, 2), 32'hFFFF_FFFF);
    rd(a_mask(11, 2), v); check("R5 mask readback", v, 32'h41);
    wr(a_mask(11, 2), 32'h0000_0040);
    rd(a_mask(11, 2), v); check("R5 mask replace", v, 32'h40);
    wr(a_mask(11, 2), 32'h0);

    // R8: tx and rx on one destination, cleared one at a time; other lines idle
    wr(a_mask(2, 3), 32'h1);
    wr(a_mask(3, 3), 32'h1);
    fire(2, 2'b01);
    fire(3, 2'b01);
    check("R8 both pending", 32'(irq_out), 32'h8);
    rd(a_tx(3), v);       check("R6 tx bit1", v, 32'h2);
    rd(a_rx(3), v);       check("R7 rx bit1", v, 32'h2);
    wr(a_stat(2, 3), 32'h1);
    check("R8 rx alone holds line", 32'(irq_out), 32'h8);
    wr(a_stat(3, 3), 32'h1);
    check("R8 line drops", 32'(irq_out), 32'h0);
    // R9: enabling via mask after latch raises the line; disabling drops it
    wr(a_mask(2, 0), 32'h1);
    check("R9 masked-late done raises", 32'(irq_out), 32'h1);
    wr(a_mask(2, 0), 32'h40);
    check("R9 error-only mask hides done", 32'(irq_out), 32'h0);
    scrub(2, 0); scrub(3, 3); wr(a_mask(2, 3), 32'h0);

    // R10: out-of-range channel and unmapped addresses
    wr(12'h900, 32'h41);
    wr(12'h0F0, 32'hFFFF_FFFF);
    rd(12'h900, v);       check("R10 channel beyond range reads 0", v, 32'h0);
    rd(a_mask(0, 0), v);  check("R10 no alias onto channel 0", v, 32'h0);
    rd(12'h0F0, v);       check("R10 unmapped reads 0", v, 32'h0);
    check("R10 irq unaffected", 32'(irq_out), 32'h0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule